// File: doc/BRIEF.md
# Single-Cycle Load-Store Processor Core

This block is a small 32-bit processor that finishes one instruction on every rising clock edge. It contains a program counter with next-address logic and a main decoder. The decoder drives a two-step ALU control. The core also has a 32-entry register file, an ALU with a zero flag, and an immediate sign extender. It executes nine operations: word load and word store, register add, subtract, AND, OR, signed set-less-than, branch-if-equal, and an absolute jump. Instruction storage and data storage are two separate internal word arrays, so a fetch and a data access can both happen in the same cycle.

A debug port lets the surrounding logic work with the core. Through it, the program and data arrays can be filled and read back, and the register file can be read. The core advances only while `run_en` is high. With `run_en` low, the core is frozen and its memories can be loaded.

Top module: `scc_top`

## Requirements
- R1: While `rst_n` is low, the PC becomes 0 and all 32 registers become 0. Reset leaves the contents of the two memory arrays unchanged.
- R2: An instruction word is split into fields: opcode [31:26], first source [25:21], second source [20:16], destination [15:11] and function [5:0]. Opcode 0 is the register-register format. In that format, function 32 adds, 34 subtracts, 36 ANDs and 37 ORs the two sources into the destination register. The word 0x02324020 writes r17+r18 into r8.
- R3: Function 42 in the register-register format compares the two sources as signed numbers. It writes 1 to the destination register when the first source is smaller, and 0 otherwise.
- R4: Opcode 35 loads a word and opcode 43 stores a word. The byte address is the first source register plus bits [15:0], sign-extended from bit 15. Address bits [1:0] are ignored. A load writes the word into the second-source register field. A store writes that register's value to memory and changes no register.
- R5: Register 0 always reads as 0. A write to register 0 has no effect.
- R6: Any instruction other than a taken branch or a jump moves the PC to PC+4. Opcode 4 branches when the two source registers are equal. A taken branch goes to PC+4 plus the sign-extended offset shifted left by two, and backward offsets are allowed.
- R7: Opcode 2 jumps to a target built from three parts: bits [31:28] of PC+4, then bits [25:0] of the instruction, then two zero bits.
- R8: An unlisted opcode, or an unlisted function code under opcode 0, writes no register and no memory, and the PC moves to PC+4.
- R9: While `run_en` is low, the PC holds its value and the core writes neither registers nor data memory.
- R10: `dbg_sel` chooses what the debug port reaches. Value 0 selects instruction words, 1 selects data words and 2 selects registers. `dbg_addr` is a word index, and `dbg_rdata` shows the selected item combinationally. `dbg_we` writes `dbg_wdata` only while `run_en` is low, and only when `dbg_sel` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset for the PC and registers |
| run_en | input | 1 | Execute one instruction per cycle when high |
| dbg_we | input | 1 | Debug write strobe (honoured only while `run_en` is low) |
| dbg_sel | input | 2 | Debug target: 0 instruction array, 1 data array, 2 registers |
| dbg_addr | input | DBG_AW | Debug word index |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data of the selected word |
| pc_o | output | 32 | Current program counter |

## Verification
The assertions assume three things about the stimulus. First, the PC is only ever fetched from word-aligned addresses. Second, debug writes arrive only while the core is halted. Third, every data address used by a program falls inside the data array. The stimulus meets these by loading programs and data only with `run_en` low. Every branch and jump target it uses is a multiple of four and lies inside the instruction array. All load and store addresses it forms stay within the first few data words. Each program ends in a branch-to-self loop, so a run that lasts longer than expected does not fetch beyond the loaded code.

// File: rtl/scc_pkg.sv
package scc_pkg;

    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_JUMP  = 6'd2;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_LOAD  = 6'd35;
    localparam logic [5:0] OPC_STORE = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [1:0] {
        AOP_ADD   = 2'b00,
        AOP_SUB   = 2'b01,
        AOP_FUNCT = 2'b10
    } alu_op_e;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_ctl_e;

    typedef struct packed {
        logic    reg_wr;
        logic    dst_rd;
        logic    mem_rd;
        logic    mem_wr;
        logic    branch;
        logic    jump;
        logic    imm_b;
        alu_op_e aluop;
    } ctrl_t;

endpackage

// File: rtl/scc_ctrl.sv
module scc_ctrl
    import scc_pkg::*;
(
    input  logic [5:0] opc,
    input  logic [5:0] fn,
    output ctrl_t      ctl_o,
    output alu_ctl_e   alu_ctl_o
);

    ctrl_t main_c;
    logic  fn_known;

    always_comb begin
        main_c       = '0;
        main_c.aluop = AOP_ADD;
        unique case (opc)
            OPC_RTYPE: begin
                main_c.reg_wr = 1'b1;
                main_c.dst_rd = 1'b1;
                main_c.aluop  = AOP_FUNCT;
            end
            OPC_LOAD: begin
                main_c.reg_wr = 1'b1;
                main_c.mem_rd = 1'b1;
                main_c.imm_b  = 1'b1;
            end
            OPC_STORE: begin
                main_c.mem_wr = 1'b1;
                main_c.imm_b  = 1'b1;
            end
            OPC_BEQ: begin
                main_c.branch = 1'b1;
                main_c.aluop  = AOP_SUB;
            end
            OPC_JUMP: begin
                main_c.jump = 1'b1;
            end
            default: begin
                main_c.aluop = AOP_ADD;
            end
        endcase
    end

    always_comb begin
        fn_known  = 1'b1;
        alu_ctl_o = ALU_ADD;
        unique case (main_c.aluop)
            AOP_ADD: alu_ctl_o = ALU_ADD;
            AOP_SUB: alu_ctl_o = ALU_SUB;
            AOP_FUNCT: begin
                unique case (fn)
                    FN_ADD:  alu_ctl_o = ALU_ADD;
                    FN_SUB:  alu_ctl_o = ALU_SUB;
                    FN_AND:  alu_ctl_o = ALU_AND;
                    FN_OR:   alu_ctl_o = ALU_OR;
                    FN_SLT:  alu_ctl_o = ALU_SLT;
                    default: fn_known  = 1'b0;
                endcase
            end
            default: fn_known = 1'b0;
        endcase
    end

    always_comb begin
        ctl_o        = main_c;
        ctl_o.reg_wr = main_c.reg_wr & fn_known;
    end

endmodule

// File: rtl/scc_alu.sv
module scc_alu
    import scc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  alu_ctl_e        ctl_i,
    output logic [XLEN-1:0] y_o,
    output logic            zero_o
);

    always_comb begin
        unique case (ctl_i)
            ALU_AND: y_o = a_i & b_i;
            ALU_OR:  y_o = a_i | b_i;
            ALU_ADD: y_o = a_i + b_i;
            ALU_SUB: y_o = a_i - b_i;
            ALU_SLT: y_o = ($signed(a_i) < $signed(b_i)) ? XLEN'(1) : '0;
            default: y_o = '0;
        endcase
    end

    assign zero_o = (y_o == '0);

endmodule

// File: rtl/scc_regfile.sv
module scc_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int RAW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RAW-1:0]  ra1_i,
    input  logic [RAW-1:0]  ra2_i,
    input  logic [RAW-1:0]  ra3_i,
    input  logic            we_i,
    input  logic [RAW-1:0]  wa_i,
    input  logic [XLEN-1:0] wd_i,
    output logic [XLEN-1:0] rd1_o,
    output logic [XLEN-1:0] rd2_o,
    output logic [XLEN-1:0] rd3_o
);

    logic [XLEN-1:0] regs_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we_i && (wa_i != '0)) begin
            regs_q[wa_i] <= wd_i;
        end
    end

    assign rd1_o = (ra1_i == '0) ? '0 : regs_q[ra1_i];
    assign rd2_o = (ra2_i == '0) ? '0 : regs_q[ra2_i];
    assign rd3_o = (ra3_i == '0) ? '0 : regs_q[ra3_i];

endmodule

// File: rtl/scc_top.sv
module scc_top
    import scc_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int DBG_AW     = 8,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              dbg_we,
    input  logic [1:0]        dbg_sel,
    input  logic [DBG_AW-1:0] dbg_addr,
    input  logic [XLEN-1:0]   dbg_wdata,
    output logic [XLEN-1:0]   dbg_rdata,
    output logic [XLEN-1:0]   pc_o
);

    localparam logic [1:0] SEL_IMEM = 2'd0;
    localparam logic [1:0] SEL_DMEM = 2'd1;
    localparam logic [1:0] SEL_REGS = 2'd2;

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_target, jmp_target;
    logic [XLEN-1:0] instr, imm_ext, rs_val, rt_val, alu_b, alu_y, wb_data, reg_dbg;
    logic [4:0]      wr_addr;
    logic            alu_zero, rf_we, dm_we;
    ctrl_t           ctl;
    alu_ctl_e        alu_ctl;

    assign instr   = imem[pc_q[IAW+1:2]];
    assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};

    scc_ctrl u_ctrl (
        .opc       (instr[31:26]),
        .fn        (instr[5:0]),
        .ctl_o     (ctl),
        .alu_ctl_o (alu_ctl)
    );

    scc_regfile #(.XLEN(XLEN), .NREG(32)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1_i (instr[25:21]),
        .ra2_i (instr[20:16]),
        .ra3_i (dbg_addr[4:0]),
        .we_i  (rf_we),
        .wa_i  (wr_addr),
        .wd_i  (wb_data),
        .rd1_o (rs_val),
        .rd2_o (rt_val),
        .rd3_o (reg_dbg)
    );

    assign alu_b = ctl.imm_b ? imm_ext : rt_val;

    scc_alu #(.XLEN(XLEN)) u_alu (
        .a_i    (rs_val),
        .b_i    (alu_b),
        .ctl_i  (alu_ctl),
        .y_o    (alu_y),
        .zero_o (alu_zero)
    );

    assign wr_addr = ctl.dst_rd ? instr[15:11] : instr[20:16];
    assign wb_data = ctl.mem_rd ? dmem[alu_y[DAW+1:2]] : alu_y;
    assign rf_we   = run_en & ctl.reg_wr;
    assign dm_we   = run_en & ctl.mem_wr;

    assign pc_plus4   = pc_q + XLEN'(4);
    assign br_target  = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign jmp_target = {pc_plus4[31:28], instr[25:0], 2'b00};

    always_comb begin
        if (ctl.jump)                   pc_next = jmp_target;
        else if (ctl.branch && alu_zero) pc_next = br_target;
        else                            pc_next = pc_plus4;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pc_q <= '0;
        else if (run_en) pc_q <= pc_next;
    end

    always_ff @(posedge clk) begin
        if (dm_we) begin
            dmem[alu_y[DAW+1:2]] <= rt_val;
        end else if (!run_en && dbg_we && dbg_sel == SEL_DMEM) begin
            dmem[dbg_addr[DAW-1:0]] <= dbg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!run_en && dbg_we && dbg_sel == SEL_IMEM) begin
            imem[dbg_addr[IAW-1:0]] <= dbg_wdata;
        end
    end

    always_comb begin
        unique case (dbg_sel)
            SEL_IMEM: dbg_rdata = imem[dbg_addr[IAW-1:0]];
            SEL_DMEM: dbg_rdata = dmem[dbg_addr[DAW-1:0]];
            SEL_REGS: dbg_rdata = reg_dbg;
            default:  dbg_rdata = '0;
        endcase
    end

    assign pc_o = pc_q;

    logic unused_bits;
    assign unused_bits = ^{pc_q[1:0], pc_q[XLEN-1:IAW+2], alu_y[1:0], alu_y[XLEN-1:DAW+2],
                           dbg_addr, instr[10:6]};

endmodule

// File: rtl/scc_chk.sv
module scc_chk #(
    parameter int XLEN   = 32,
    parameter int DBG_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic [1:0]        dbg_sel,
    input logic [DBG_AW-1:0] dbg_addr,
    input logic [XLEN-1:0]   dbg_rdata,
    input logic [XLEN-1:0]   pc_o,
    input logic [XLEN-1:0]   instr,
    input logic [XLEN-1:0]   rs_val,
    input logic [XLEN-1:0]   rt_val,
    input logic              dm_we
);

    logic [5:0]      opc;
    logic [XLEN-1:0] off_sh;
    assign opc    = instr[31:26];
    assign off_sh = {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};

    // R6
    pc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_o[1:0] == 2'b00);

    // R9
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> $stable(pc_o));

    // R6
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && opc != 6'd4 && opc != 6'd2) |=> pc_o == $past(pc_o) + XLEN'(4));

    // R6
    beq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && opc == 6'd4) |=>
        pc_o == ($past(rs_val == rt_val) ? $past(pc_o + XLEN'(4) + off_sh)
                                          : $past(pc_o) + XLEN'(4)));

    // R7
    jump_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && opc == 6'd2) |=>
        pc_o == $past({pc_o[31:28] + ((pc_o[27:0] > 28'hFFFFFFB) ? 4'd1 : 4'd0),
                       instr[25:0], 2'b00}));

    // R5
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_sel == 2'd2 && dbg_addr[4:0] == 5'd0) |-> dbg_rdata == '0);

    // R8
    store_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dm_we |-> (run_en && opc == 6'd43));

endmodule

bind scc_top scc_chk #(.XLEN(XLEN), .DBG_AW(DBG_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .dbg_sel   (dbg_sel),
    .dbg_addr  (dbg_addr),
    .dbg_rdata (dbg_rdata),
    .pc_o      (pc_o),
    .instr     (instr),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .dm_we     (dm_we)
);

// File: tb/test_scc_top.sv
module test_scc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        dbg_we = 1'b0;
    logic [1:0]  dbg_sel = 2'd0;
    logic [7:0]  dbg_addr = '0;
    logic [31:0] dbg_wdata = '0;
    logic [31:0] dbg_rdata;
    logic [31:0] pc_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    scc_top i_scc_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .dbg_we    (dbg_we),
        .dbg_sel   (dbg_sel),
        .dbg_addr  (dbg_addr),
        .dbg_wdata (dbg_wdata),
        .dbg_rdata (dbg_rdata),
        .pc_o      (pc_o)
    );

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'd0, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic dbg_write(input logic [1:0] sel, input int addr, input logic [31:0] d);
        @(negedge clk);
        dbg_sel = sel; dbg_addr = 8'(addr); dbg_wdata = d; dbg_we = 1'b1;
        @(negedge clk);
        dbg_we = 1'b0;
    endtask

    task automatic dbg_read(input logic [1:0] sel, input int addr, output logic [31:0] d);
        @(negedge clk);
        dbg_sel = sel; dbg_addr = 8'(addr);
        #1;
        d = dbg_rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run_to(input logic [31:0] stop_pc, input int limit);
        @(negedge clk);
        run_en = 1'b1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (pc_o == stop_pc) break;
        end
        run_en = 1'b0;
    endtask

    task automatic run_cycles(input int n);
        @(negedge clk);
        run_en = 1'b1;
        repeat (n) @(negedge clk);
        run_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        check("R1", "pc after reset", pc_o, 32'd0);
        dbg_read(2'd2, 8, v);
        check("R1", "r8 after reset", v, 32'd0);
    endtask

    task automatic t_alu_mem();
        logic [31:0] v;
        dbg_write(2'd1, 0, 32'd7);
        dbg_write(2'd1, 1, 32'd5);
        dbg_write(2'd1, 2, 32'hFFFF_FFFD);
        dbg_write(2'd1, 3, 32'hDEAD_0003);
        dbg_write(2'd1, 4, 32'd8);
        dbg_write(2'd1, 5, 32'h5555_AAAA);
        dbg_write(2'd0, 0,  enc_i(6'd35, 5'd0, 5'd17, 16'd0));
        dbg_write(2'd0, 1,  enc_i(6'd35, 5'd0, 5'd18, 16'd4));
        dbg_write(2'd0, 2,  enc_i(6'd35, 5'd0, 5'd3, 16'd8));
        dbg_write(2'd0, 3,  32'h0232_4020);
        dbg_write(2'd0, 4,  enc_r(5'd17, 5'd18, 5'd5, 6'd34));
        dbg_write(2'd0, 5,  enc_r(5'd17, 5'd18, 5'd6, 6'd36));
        dbg_write(2'd0, 6,  enc_r(5'd17, 5'd18, 5'd7, 6'd37));
        dbg_write(2'd0, 7,  enc_r(5'd3, 5'd17, 5'd9, 6'd42));
        dbg_write(2'd0, 8,  enc_r(5'd17, 5'd3, 5'd10, 6'd42));
        dbg_write(2'd0, 9,  enc_i(6'd35, 5'd0, 5'd11, 16'd16));
        dbg_write(2'd0, 10, enc_i(6'd43, 5'd11, 5'd8, 16'hFFFC));
        dbg_write(2'd0, 11, enc_i(6'd43, 5'd0, 5'd5, 16'd12));
        dbg_write(2'd0, 12, enc_r(5'd17, 5'd18, 5'd0, 6'd32));
        dbg_write(2'd0, 13, enc_i(6'd8, 5'd0, 5'd6, 16'd9));
        dbg_write(2'd0, 14, enc_r(5'd17, 5'd18, 5'd7, 6'd39));
        dbg_write(2'd0, 15, enc_i(6'd35, 5'd0, 5'd12, 16'd4));
        do_reset();
        run_to(32'd64, 40);
        check("R6", "pc after straight-line program", pc_o, 32'd64);
        dbg_read(2'd2, 8, v);  check("R2", "r8 from 0x02324020", v, 32'd12);
        dbg_read(2'd2, 5, v);  check("R2", "sub r5", v, 32'd2);
        dbg_read(2'd2, 6, v);  check("R8", "r6 and-result kept after unknown opcode", v, 32'd5);
        dbg_read(2'd2, 7, v);  check("R8", "r7 or-result kept after unknown funct", v, 32'd7);
        dbg_read(2'd2, 9, v);  check("R3", "slt -3<7", v, 32'd1);
        dbg_read(2'd2, 10, v); check("R3", "slt 7<-3", v, 32'd0);
        dbg_read(2'd2, 0, v);  check("R5", "r0 after write", v, 32'd0);
        dbg_read(2'd1, 1, v);  check("R4", "store with negative offset", v, 32'd12);
        dbg_read(2'd1, 3, v);  check("R4", "store with positive offset", v, 32'd2);
        dbg_read(2'd2, 12, v); check("R4", "load after store", v, 32'd12);
        dbg_read(2'd1, 0, v);  check("R4", "untouched data word 0", v, 32'd7);
        dbg_read(2'd1, 5, v);  check("R8", "data word 5 untouched", v, 32'h5555_AAAA);
        dbg_read(2'd2, 11, v); check("R4", "lw base r11", v, 32'd8);
    endtask

    task automatic t_branch_jump();
        logic [31:0] v;
        dbg_write(2'd1, 0, 32'd7);
        dbg_write(2'd1, 1, 32'd5);
        dbg_write(2'd0, 0,  enc_i(6'd4, 5'd0, 5'd0, 16'd2));
        dbg_write(2'd0, 1,  enc_i(6'd35, 5'd0, 5'd1, 16'd0));
        dbg_write(2'd0, 2,  enc_i(6'd35, 5'd0, 5'd1, 16'd0));
        dbg_write(2'd0, 3,  enc_i(6'd35, 5'd0, 5'd2, 16'd0));
        dbg_write(2'd0, 4,  enc_i(6'd4, 5'd2, 5'd0, 16'd1));
        dbg_write(2'd0, 5,  enc_i(6'd35, 5'd0, 5'd3, 16'd4));
        dbg_write(2'd0, 6,  {6'd2, 26'd10});
        dbg_write(2'd0, 7,  enc_i(6'd35, 5'd0, 5'd4, 16'd0));
        dbg_write(2'd0, 10, enc_i(6'd4, 5'd0, 5'd0, 16'hFFFF));
        do_reset();
        run_cycles(20);
        check("R6", "backward branch-to-self pc", pc_o, 32'd40);
        dbg_read(2'd2, 1, v); check("R6", "taken branch skipped r1", v, 32'd0);
        dbg_read(2'd2, 2, v); check("R6", "target load r2", v, 32'd7);
        dbg_read(2'd2, 3, v); check("R6", "not-taken path r3", v, 32'd5);
        dbg_read(2'd2, 4, v); check("R7", "jump skipped r4", v, 32'd0);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        repeat (5) @(negedge clk);
        check("R9", "pc held while halted", pc_o, 32'd40);
        dbg_write(2'd2, 2, 32'h1234_5678);
        dbg_read(2'd2, 2, v); check("R10", "register not debug-writable", v, 32'd7);
        dbg_write(2'd1, 9, 32'hCAFE_F00D);
        dbg_read(2'd1, 9, v); check("R10", "debug data write", v, 32'hCAFE_F00D);
        dbg_read(2'd0, 6, v); check("R10", "debug instruction read", v, {6'd2, 26'd10});
        @(negedge clk);
        run_en = 1'b1; dbg_sel = 2'd1; dbg_addr = 8'd9; dbg_wdata = 32'h0; dbg_we = 1'b1;
        @(negedge clk);
        dbg_we = 1'b0; run_en = 1'b0;
        dbg_read(2'd1, 9, v); check("R10", "debug write ignored while running", v, 32'hCAFE_F00D);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_alu_mem();
        t_branch_jump();
        t_hold();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule